// File: doc/BRIEF.md
# PLL Power-Up and Lock Sequencer

This block controls a reference-clock multiplier PLL. Software-facing pulses ask it to bring the PLL up or take it down. On a bring-up request it steps through four control changes, one per clock: it releases the PLL's active-low soft reset, selects the good-reference loop bandwidth, applies the staged multiplier code, and then powers the PLL up. After that it waits for the PLL's lock indication. The lock indication is treated as asynchronous and passes through a two-flop synchroniser first. If lock does not arrive within a parameterised number of system clocks, the block raises a sticky timeout error. Take-down reverses the order: power-down first, soft reset on the following clock.

The multiplier code is 3 bits wide and the PLL multiplies by the code plus 16. A code can be written directly, or derived from a requested pair of input and output frequencies in MHz. The block range-checks the requested pair and rejects it when the pair is out of range. While the PLL is running, a newly accepted code goes straight to the PLL without a new lock wait. While the PLL is off, a new code is only staged and takes effect at the next bring-up.

Top module: `pll_bringup_seq`

## Requirements
- R1: After reset: pll_rst_n=0, bw_sel=1 (very-bad-reference code), mult_code=0, pd_ctl at the power-down level, enabled=0, locked=0, timeout_err=0, rate_reject=0, mult_factor=16.
- R2: A bring-up request seen while off produces changes on four successive clock edges, in this order: pll_rst_n goes to 1; bw_sel goes to 0 (good reference; 1=very bad, 2=bad, 3=very good); mult_code takes the staged code; pd_ctl goes to the power-up level.
- R3: lock_in passes through two synchroniser flops. Once power is up, the first edge that sees the synchronised lock high sets locked, which then stays high until take-down.
- R4: If the synchronised lock stays low for LOCK_WAIT_CYC edges after power-up, timeout_err rises on that last edge and locked stays 0. The error holds until a take-down request clears it.
- R5: A take-down request while waiting, locked or in error drives pd_ctl to the power-down level (enabled=0, locked=0) on the next edge, and drives pll_rst_n low on the edge after that. bw_sel is left unchanged.
- R6: The PD_UP_LEVEL parameter sets the pd_ctl level that means powered (default 0). enabled is 1 exactly when pd_ctl equals that level.
- R7: mult_factor always equals mult_code + 16.
- R8: A code write (code_wr with code_in) while enabled updates mult_code on the next edge, and locked stays set. While off, a code write only stages the value and leaves mult_code unchanged.
- R9: A rate request (rate_req with fin_mhz, fout_mhz) computes the integer quotient fout_mhz / fin_mhz. A quotient below 16 is clamped to 16, and the code becomes the quotient minus 16. An accepted code is handled like a code write (R8).
- R10: A rate request is rejected when fin_mhz is 0, fin_mhz is above 40, fout_mhz is below 384 or above 660, or the quotient is above 23. On rejection rate_reject is 1 for exactly one cycle and no code changes.
- R11: When code_wr and rate_req are asserted in the same cycle, the direct code wins and the rate request is dropped with no rejection.
- R12: A bring-up request while waiting, locked or in error is ignored. A take-down request while off is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_on | input | 1 | Bring-up request pulse |
| req_off | input | 1 | Take-down request pulse |
| code_wr | input | 1 | Direct multiplier code write strobe |
| code_in | input | CODE_W | Multiplier code to write |
| rate_req | input | 1 | Frequency-pair request strobe |
| fin_mhz | input | FIN_W | Requested reference frequency in MHz |
| fout_mhz | input | FOUT_W | Requested output frequency in MHz |
| lock_in | input | 1 | Asynchronous PLL lock indication |
| pll_rst_n | output | 1 | Active-low soft reset to the PLL |
| bw_sel | output | 2 | Reference bandwidth select to the PLL |
| mult_code | output | CODE_W | Multiplier code applied to the PLL |
| pd_ctl | output | 1 | Power-down control to the PLL |
| enabled | output | 1 | PLL powered, derived from pd_ctl |
| locked | output | 1 | Lock reached after bring-up |
| timeout_err | output | 1 | Lock wait expired |
| rate_reject | output | 1 | One-cycle pulse on a rejected rate request |
| mult_factor | output | FACTOR_W | Effective multiplication factor |

## Verification
The assertions check ordering invariants on every cycle. Power is never up while the PLL is held in reset. The bandwidth code is already 0 when power rises. Reset never falls in the same cycle that power goes down. locked never coexists with an error or with power off. A rejected rate request never disturbs a running code. Only the bench scenarios can show the exact cycle of each bring-up step, the timeout count, the quotient and clamp arithmetic, the staged versus live code paths, the write priority, and the ignored requests.

// File: rtl/pll_seq_pkg.sv
// Package: shared state encoding and constants for the PLL sequencer.
// Assumes the multiplier offset and bandwidth codes are fixed by the PLL.
package pll_seq_pkg;

    localparam int MULT_BASE = 16;

    localparam logic [1:0] BW_GOOD  = 2'd0;
    localparam logic [1:0] BW_VBAD  = 2'd1;
    localparam logic [1:0] BW_BAD   = 2'd2;
    localparam logic [1:0] BW_VGOOD = 2'd3;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_BW     = 3'd1,
        ST_MULT   = 3'd2,
        ST_PWR    = 3'd3,
        ST_WAIT   = 3'd4,
        ST_ON     = 3'd5,
        ST_ERR    = 3'd6,
        ST_DN_RST = 3'd7
    } seq_state_t;

endpackage

// File: rtl/pll_lock_sync.sv
// Module: multi-flop synchroniser for the asynchronous lock indication.
// Assumes lock_in is quasi-static compared with the system clock.
module pll_lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/pll_rate_check.sv
// Module: turns a requested input/output frequency pair into a multiplier
// code and range-checks it. Purely combinational; the caller registers.
// Assumes both frequencies are integers in MHz.
module pll_rate_check
    import pll_seq_pkg::*;
#(
    parameter int FIN_W        = 8,
    parameter int FOUT_W       = 10,
    parameter int CODE_W       = 3,
    parameter int FIN_MAX_MHZ  = 40,
    parameter int FOUT_MIN_MHZ = 384,
    parameter int FOUT_MAX_MHZ = 660
) (
    input  logic [FIN_W-1:0]  fin_mhz,
    input  logic [FOUT_W-1:0] fout_mhz,
    output logic              rate_ok,
    output logic [CODE_W-1:0] rate_code
);

    localparam int QW       = FOUT_W;
    localparam int MULT_TOP = MULT_BASE + (1 << CODE_W) - 1;

    logic [QW-1:0] quo;
    logic [QW-1:0] clamped;
    logic [QW-1:0] offset;
    logic          fin_bad;
    logic          fout_bad;

    // Integer quotient, guarded against a zero divisor.
    always_comb begin
        if (fin_mhz == '0) quo = '0;
        else               quo = fout_mhz / QW'(fin_mhz);
    end

    // Clamp small factors to the base and form the register code.
    always_comb begin
        clamped = (quo < QW'(MULT_BASE)) ? QW'(MULT_BASE) : quo;
        offset  = clamped - QW'(MULT_BASE);
    end

    // Range checks on the request.
    always_comb begin
        fin_bad  = (fin_mhz == '0) || (fin_mhz > FIN_W'(FIN_MAX_MHZ));
        fout_bad = (fout_mhz < FOUT_W'(FOUT_MIN_MHZ)) ||
                   (fout_mhz > FOUT_W'(FOUT_MAX_MHZ));
        rate_ok  = !fin_bad && !fout_bad && (clamped <= QW'(MULT_TOP));
    end

    assign rate_code = offset[CODE_W-1:0];

endmodule

// File: rtl/pll_seq_fsm.sv
// Module: bring-up / take-down state machine with a lock wait timer.
// Assumes req_on and req_off are single-cycle pulses and lock_s is
// already synchronised. Intermediate bring-up steps ignore requests.
module pll_seq_fsm
    import pll_seq_pkg::*;
#(
    parameter int   LOCK_WAIT_CYC = 2_500_000,
    parameter logic PD_UP_LEVEL   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_on,
    input  logic req_off,
    input  logic lock_s,
    output logic pll_rst_n,
    output logic [1:0] bw_sel,
    output logic pd_ctl,
    output logic load_code,
    output logic live,
    output logic locked,
    output logic timeout_err
);

    localparam int TW = $clog2(LOCK_WAIT_CYC + 1);
    localparam logic [TW-1:0] TLAST = TW'(LOCK_WAIT_CYC - 1);

    seq_state_t    state;
    logic [TW-1:0] timer;

    // State register, control outputs and lock timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_OFF;
            pll_rst_n   <= 1'b0;
            bw_sel      <= BW_VBAD;
            pd_ctl      <= ~PD_UP_LEVEL;
            timer       <= '0;
            timeout_err <= 1'b0;
        end else begin
            case (state)
                ST_OFF: begin
                    if (req_on) begin
                        pll_rst_n   <= 1'b1;
                        timeout_err <= 1'b0;
                        state       <= ST_BW;
                    end
                end
                ST_BW: begin
                    bw_sel <= BW_GOOD;
                    state  <= ST_MULT;
                end
                ST_MULT: begin
                    state <= ST_PWR;
                end
                ST_PWR: begin
                    pd_ctl <= PD_UP_LEVEL;
                    timer  <= '0;
                    state  <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (req_off) begin
                        pd_ctl <= ~PD_UP_LEVEL;
                        state  <= ST_DN_RST;
                    end else if (lock_s) begin
                        state <= ST_ON;
                    end else if (timer == TLAST) begin
                        timeout_err <= 1'b1;
                        state       <= ST_ERR;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                ST_ON: begin
                    if (req_off) begin
                        pd_ctl <= ~PD_UP_LEVEL;
                        state  <= ST_DN_RST;
                    end
                end
                ST_ERR: begin
                    if (req_off) begin
                        pd_ctl      <= ~PD_UP_LEVEL;
                        timeout_err <= 1'b0;
                        state       <= ST_DN_RST;
                    end
                end
                ST_DN_RST: begin
                    pll_rst_n <= 1'b0;
                    state     <= ST_OFF;
                end
                default: state <= ST_OFF;
            endcase
        end
    end

    // State decodes for the code path and status.
    assign load_code = (state == ST_MULT);
    assign live      = (state == ST_WAIT) || (state == ST_ON) || (state == ST_ERR);
    assign locked    = (state == ST_ON);

endmodule

// File: rtl/pll_bringup_seq.sv
// Module: top of the PLL sequencer. Holds the staged and applied multiplier
// codes, arbitrates direct and rate-derived writes, and wires the FSM.
// Assumes single-cycle request strobes from a register interface.
module pll_bringup_seq
    import pll_seq_pkg::*;
#(
    parameter int   CODE_W        = 3,
    parameter int   FACTOR_W      = 5,
    parameter int   FIN_W         = 8,
    parameter int   FOUT_W        = 10,
    parameter int   LOCK_WAIT_CYC = 2_500_000,
    parameter int   SYNC_STAGES   = 2,
    parameter logic PD_UP_LEVEL   = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_on,
    input  logic                req_off,
    input  logic                code_wr,
    input  logic [CODE_W-1:0]   code_in,
    input  logic                rate_req,
    input  logic [FIN_W-1:0]    fin_mhz,
    input  logic [FOUT_W-1:0]   fout_mhz,
    input  logic                lock_in,
    output logic                pll_rst_n,
    output logic [1:0]          bw_sel,
    output logic [CODE_W-1:0]   mult_code,
    output logic                pd_ctl,
    output logic                enabled,
    output logic                locked,
    output logic                timeout_err,
    output logic                rate_reject,
    output logic [FACTOR_W-1:0] mult_factor
);

    logic              lock_s;
    logic              load_code;
    logic              live;
    logic              rate_ok;
    logic [CODE_W-1:0] rate_code;
    logic [CODE_W-1:0] staged;
    logic              new_valid;
    logic [CODE_W-1:0] new_code;

    pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (lock_in),
        .sync_out (lock_s)
    );

    pll_rate_check #(
        .FIN_W  (FIN_W),
        .FOUT_W (FOUT_W),
        .CODE_W (CODE_W)
    ) u_rate (
        .fin_mhz   (fin_mhz),
        .fout_mhz  (fout_mhz),
        .rate_ok   (rate_ok),
        .rate_code (rate_code)
    );

    pll_seq_fsm #(
        .LOCK_WAIT_CYC (LOCK_WAIT_CYC),
        .PD_UP_LEVEL   (PD_UP_LEVEL)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_on      (req_on),
        .req_off     (req_off),
        .lock_s      (lock_s),
        .pll_rst_n   (pll_rst_n),
        .bw_sel      (bw_sel),
        .pd_ctl      (pd_ctl),
        .load_code   (load_code),
        .live        (live),
        .locked      (locked),
        .timeout_err (timeout_err)
    );

    // Arbitrate the two write sources; the direct code has priority.
    always_comb begin
        new_valid = code_wr || (rate_req && rate_ok);
        new_code  = code_wr ? code_in : rate_code;
    end

    // Staged code, applied code and the rejection pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged      <= '0;
            mult_code   <= '0;
            rate_reject <= 1'b0;
        end else begin
            rate_reject <= rate_req && !code_wr && !rate_ok;
            if (new_valid) staged <= new_code;
            if (load_code)                  mult_code <= staged;
            else if (live && new_valid)     mult_code <= new_code;
        end
    end

    // Status derived from the applied controls.
    assign enabled     = (pd_ctl == PD_UP_LEVEL);
    assign mult_factor = FACTOR_W'(mult_code) + FACTOR_W'(MULT_BASE);

endmodule

// File: rtl/pll_bringup_seq_chk.sv
// Checker: ordering and status invariants of the PLL sequencer.
module pll_bringup_seq_chk #(
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pll_rst_n,
    input logic [1:0]        bw_sel,
    input logic [CODE_W-1:0] mult_code,
    input logic              enabled,
    input logic              locked,
    input logic              timeout_err,
    input logic              rate_reject
);

    // R2
    pwr_needs_rst_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enabled |-> pll_rst_n);

    // R2
    bw_before_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enabled) |-> (bw_sel == 2'd0));

    // R5
    pd_before_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_rst_n) |-> (!enabled && !$past(enabled)));

    // R3
    locked_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (enabled && !timeout_err));

    // R4
    err_while_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (enabled && !locked));

    // R10
    reject_keeps_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_reject && enabled && $past(enabled)) |-> $stable(mult_code));

endmodule

bind pll_bringup_seq pll_bringup_seq_chk #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pll_rst_n   (pll_rst_n),
    .bw_sel      (bw_sel),
    .mult_code   (mult_code),
    .enabled     (enabled),
    .locked      (locked),
    .timeout_err (timeout_err),
    .rate_reject (rate_reject)
);

// File: tb/pll_bringup_seq_bench.sv
// Scoreboard bench: the driver queues expected output snapshots tagged with
// the cycle they are due; a monitor compares them one ns after each edge.
module pll_bringup_seq_bench;

    localparam int LIM = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_on = 1'b0, req_off = 1'b0, code_wr = 1'b0, rate_req = 1'b0;
    logic [2:0] code_in = '0;
    logic [7:0] fin_mhz = '0;
    logic [9:0] fout_mhz = '0;
    logic       lock_in = 1'b0;
    logic       pll_rst_n, pd_ctl, enabled, locked, timeout_err, rate_reject;
    logic [1:0] bw_sel;
    logic [2:0] mult_code;
    logic [4:0] mult_factor;

    pll_bringup_seq #(.LOCK_WAIT_CYC(LIM)) u_pll_bringup_seq (
        .clk(clk), .rst_n(rst_n), .req_on(req_on), .req_off(req_off),
        .code_wr(code_wr), .code_in(code_in), .rate_req(rate_req),
        .fin_mhz(fin_mhz), .fout_mhz(fout_mhz), .lock_in(lock_in),
        .pll_rst_n(pll_rst_n), .bw_sel(bw_sel), .mult_code(mult_code),
        .pd_ctl(pd_ctl), .enabled(enabled), .locked(locked),
        .timeout_err(timeout_err), .rate_reject(rate_reject),
        .mult_factor(mult_factor)
    );

    always #2 clk = ~clk;

    typedef struct {
        int          cyc;
        logic [15:0] v;
        string       tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    // Requirement model state.
    logic       m_rst = 0, m_en = 0, m_lock = 0, m_err = 0, m_rej = 0;
    logic [1:0] m_bw = 2'd1;
    logic [2:0] m_code = 3'd0;

    function automatic logic [15:0] model_vec();
        logic [4:0] fac;
        fac = 5'(m_code) + 5'd16;
        return {m_rst, m_bw, m_code, ~m_en, m_en, m_lock, m_err, m_rej, fac};
    endfunction

    task automatic exp_at(input int c, input string tag);
        item_t it;
        it.cyc = c;
        it.v   = model_vec();
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare due snapshots just after each rising edge.
    initial begin
        forever begin
            logic [15:0] obs;
            item_t it;
            @(posedge clk);
            cyc = cyc + 1;
            #1;
            obs = {pll_rst_n, bw_sel, mult_code, pd_ctl, enabled, locked,
                   timeout_err, rate_reject, mult_factor};
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                it = q.pop_front();
                n_vec++;
                if (it.cyc != cyc || obs !== it.v) begin
                    n_bad++;
                    $display("FAIL %s cyc %0d: actual %h expected %h",
                             it.tag, cyc, obs, it.v);
                end
            end
        end
    end

    task automatic rate_case(input int fin, input int fout, input bit ok,
                             input logic [2:0] code, input string tag);
        int b;
        b = cyc;
        fin_mhz  = 8'(fin);
        fout_mhz = 10'(fout);
        rate_req = 1'b1;
        if (ok) m_code = code;
        else    m_rej  = 1'b1;
        exp_at(b + 1, tag);
        m_rej = 1'b0;
        exp_at(b + 2, tag);
        tick(1);
        rate_req = 1'b0;
        tick(2);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Driver.
    initial begin
        int b;
        tick(5);
        rst_n = 1'b1;
        b = cyc;
        exp_at(b + 1, "R1 reset state");
        lock_in = 1'b1;
        tick(4);

        // R8: code write while off is only staged.
        b = cyc; code_wr = 1'b1; code_in = 3'd5;
        exp_at(b + 1, "R8 staged write while off");
        tick(1); code_wr = 1'b0;
        // R12: take-down while off ignored.
        b = cyc; req_off = 1'b1;
        exp_at(b + 1, "R12 off request while off");
        tick(1); req_off = 1'b0;
        tick(2);

        // R2, R3, R6, R7: bring-up order then lock.
        b = cyc; req_on = 1'b1;
        m_rst = 1;  exp_at(b + 1, "R2 reset released first");
        m_bw = 0;   exp_at(b + 2, "R2 bandwidth good second");
        m_code = 5; exp_at(b + 3, "R2 R7 code applied third");
        m_en = 1;   exp_at(b + 4, "R2 R6 power up fourth");
        m_lock = 1; exp_at(b + 5, "R3 locked after sync");
        tick(1); req_on = 1'b0;
        tick(6);

        // R8: live write keeps lock.
        b = cyc; code_wr = 1'b1; code_in = 3'd2;
        m_code = 2; exp_at(b + 1, "R8 live code write");
        tick(1); code_wr = 1'b0;
        // R12: bring-up while locked ignored.
        b = cyc; req_on = 1'b1;
        exp_at(b + 1, "R12 on request while locked");
        exp_at(b + 3, "R12 no sequence rerun");
        tick(1); req_on = 1'b0;
        tick(4);

        // R9 accepted requests.
        rate_case(25, 500, 1, 3'd4, "R9 quotient 20");
        rate_case(17, 384, 1, 3'd6, "R9 quotient 22 at low bound");
        rate_case(40, 400, 1, 3'd0, "R9 clamp to 16");
        // R10 rejected requests.
        rate_case(41, 500, 0, 3'd0, "R10 fin above 40");
        rate_case(20, 600, 0, 3'd0, "R10 quotient 30");
        rate_case(20, 383, 0, 3'd0, "R10 fout below 384");
        rate_case(30, 661, 0, 3'd0, "R10 fout above 660");
        rate_case(0, 500, 0, 3'd0, "R10 fin zero");

        // R11: direct write beats rate request.
        b = cyc; code_wr = 1'b1; code_in = 3'd7;
        rate_req = 1'b1; fin_mhz = 8'd41; fout_mhz = 10'd500;
        m_code = 7; exp_at(b + 1, "R11 direct write wins");
        exp_at(b + 2, "R11 no reject pulse");
        tick(1); code_wr = 1'b0; rate_req = 1'b0;
        tick(2);

        // R5: take-down order.
        b = cyc; req_off = 1'b1;
        m_en = 0; m_lock = 0; exp_at(b + 1, "R5 power down first");
        m_rst = 0;            exp_at(b + 2, "R5 reset second");
        tick(1); req_off = 1'b0;
        tick(4);

        // R4: lock timeout.
        lock_in = 1'b0;
        tick(4);
        b = cyc; req_on = 1'b1;
        m_rst = 1; exp_at(b + 1, "R4 bring-up step 1");
        exp_at(b + 3, "R4 staged code 7");
        m_en = 1;  exp_at(b + 4, "R4 powered, waiting");
        exp_at(b + 3 + LIM, "R4 no error before limit");
        m_err = 1; exp_at(b + 4 + LIM, "R4 error at limit");
        tick(1); req_on = 1'b0;
        tick(LIM + 8);
        // R12: bring-up while in error ignored.
        b = cyc; req_on = 1'b1;
        exp_at(b + 1, "R12 on request in error");
        tick(1); req_on = 1'b0;
        tick(2);
        b = cyc; req_off = 1'b1;
        m_en = 0; m_err = 0; exp_at(b + 1, "R4 R5 error cleared by take-down");
        m_rst = 0;           exp_at(b + 2, "R5 reset after error");
        tick(1); req_off = 1'b0;

        wait (q.size() == 0);
        tick(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule